// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This block sits beside a processor's control-and-status register file and handles the moment a trap is taken. When an exception or interrupt is presented, it chooses the handling level: supervisor or machine. It then computes, in the same cycle, every value the register file must capture at that clock edge. These values are the rewritten status word, the cause word, the saved exception pc, the trap value and the redirected fetch pc. It also signals that any outstanding load reservation must be dropped.

Delegation looks at the current privilege and at one bit of a delegation mask. Interrupts use the interrupt mask and exceptions use the exception mask. A single generic environment-call code is first turned into a privilege-specific code, and that converted code is the one used for delegation and reporting. The trap value carries the faulting address only for address-bearing exception causes. A per-cause vectored offset is added to the handler address only for interrupts.

All outputs are combinational and valid while `trap_valid` is high. The register file writes them on that edge. The same signal gates the ordinary register-write enable passed through this block, so no other register write lands in a trap cycle. Privilege is encoded 0 = user, 1 = supervisor, 3 = machine; the value 2 is treated as above supervisor.

Top module: `trap_entry_unit`

## Requirements
- R1: An interrupt (`trap_is_irq`=1) selects its delegation bit from `irq_deleg`; an exception (`trap_is_irq`=0) selects it from `exc_deleg`. The mask that is not selected has no effect on the chosen target.
- R2: While `trap_valid` is high, exactly one of `to_super`/`to_machine` is high. `to_super` is chosen when `cur_priv` is 0 or 1, the converted cause code is below XLEN, and the selected mask bit at that code is 1; otherwise `to_machine` is chosen. While `trap_valid` is low, both are low.
- R3: On supervisor entry, `status_out` equals `status_in` except: bit 5 takes `status_in` bit 1, bit 8 takes `cur_priv` bit 0, and bit 1 becomes 0.
- R4: On machine entry, `status_out` equals `status_in` except: bit 7 takes `status_in` bit 3, bits 12:11 take `cur_priv`, and bit 3 becomes 0.
- R5: During a trap, `cause_out` holds the converted cause code in its low bits, with bit XLEN-1 set for interrupts and clear for exceptions, and `epc_out` equals `cur_pc`.
- R6: During an exception with code 0, 1, 4, 5, 6, 7, 12, 13 or 15, `tval_out` equals `fault_addr`. For any other exception code, and for every interrupt, `tval_out` is 0.
- R7: `pc_out` is the vector register of the target level (`svec` or `mvec`) with bits 1:0 cleared. Four times the cause code is added only when the trap is an interrupt and the vector's bits 1:0 equal 1.
- R8: An exception with raw code 8 is converted before any other use to 8 from user, 9 from supervisor and 11 from machine privilege (or encoding 2).
- R9: `resv_clear` is high in every trap cycle and low in every other cycle.
- R10: `csr_we_out` equals `csr_we_in` when `trap_valid` is low and is 0 when `trap_valid` is high.
- R11: When `trap_valid` is low, `status_out` equals `status_in` and `cause_out`, `epc_out`, `tval_out` and `pc_out` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; used by the embedded checks |
| rst_n | input | 1 | Active-low reset; disables the embedded checks |
| trap_valid | input | 1 | A trap is taken at the coming clock edge |
| trap_is_irq | input | 1 | 1 = interrupt, 0 = exception |
| trap_cause | input | CAUSE_W | Raw cause code |
| fault_addr | input | XLEN | Faulting address for address-bearing exceptions |
| cur_pc | input | XLEN | pc of the trapping instruction |
| cur_priv | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| status_in | input | XLEN | Current status word |
| exc_deleg | input | XLEN | Exception delegation mask |
| irq_deleg | input | XLEN | Interrupt delegation mask |
| mvec | input | XLEN | Machine trap vector (bits 1:0 = mode) |
| svec | input | XLEN | Supervisor trap vector (bits 1:0 = mode) |
| csr_we_in | input | 1 | Ordinary register-write enable from the pipeline |
| csr_we_out | output | 1 | Write enable, blocked in a trap cycle |
| to_super | output | 1 | Trap handled at supervisor level |
| to_machine | output | 1 | Trap handled at machine level |
| status_out | output | XLEN | Status word to write |
| cause_out | output | XLEN | Cause word for the target level |
| epc_out | output | XLEN | Saved exception pc for the target level |
| tval_out | output | XLEN | Trap value for the target level |
| pc_out | output | XLEN | Handler address to fetch next |
| resv_clear | output | 1 | Drop any outstanding load reservation |

## Verification
The clocked checks take the trap inputs to be stable across each rising edge. They also assume `trap_cause` is narrower than XLEN, so the interrupt flag never overlaps code bits. The bench changes every input only on the falling edge and samples one time unit later. It keeps all causes within 6 bits, with XLEN at 32. The privilege value 2 is not driven, because the register file is expected never to hold it.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

    typedef enum logic [1:0] {
        PRV_USER  = 2'd0,
        PRV_SUPER = 2'd1,
        PRV_RSVD  = 2'd2,
        PRV_MACH  = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_SUPER = 2'd1,
        TGT_MACH  = 2'd2
    } target_e;

    localparam int unsigned ECALL_GENERIC = 8;
    localparam int unsigned ECALL_USER    = 8;
    localparam int unsigned ECALL_SUPER   = 9;
    localparam int unsigned ECALL_MACH    = 11;

    localparam int unsigned ST_SIE    = 1;
    localparam int unsigned ST_MIE    = 3;
    localparam int unsigned ST_SPIE   = 5;
    localparam int unsigned ST_MPIE   = 7;
    localparam int unsigned ST_SPP    = 8;
    localparam int unsigned ST_MPP_LO = 11;
    localparam int unsigned ST_MPP_HI = 12;

endpackage

// File: rtl/trap_route.sv
module trap_route
    import trap_entry_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned CAUSE_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap_valid,
    input  logic               is_irq,
    input  logic [CAUSE_W-1:0] cause_raw,
    input  priv_e              priv,
    input  logic [XLEN-1:0]    exc_deleg,
    input  logic [XLEN-1:0]    irq_deleg,
    output logic [CAUSE_W-1:0] code,
    output target_e            target
);
    localparam int unsigned IDX_W = $clog2(XLEN);

    logic [XLEN-1:0] mask_sel;
    logic [31:0]     code_wide;
    logic            code_in_range;
    logic            mask_bit;
    logic            low_priv;

    // environment-call conversion happens before delegation
    always_comb begin
        code = cause_raw;
        if (!is_irq && cause_raw == CAUSE_W'(ECALL_GENERIC)) begin
            unique case (priv)
                PRV_USER:  code = CAUSE_W'(ECALL_USER);
                PRV_SUPER: code = CAUSE_W'(ECALL_SUPER);
                default:   code = CAUSE_W'(ECALL_MACH);
            endcase
        end
    end

    assign mask_sel      = is_irq ? irq_deleg : exc_deleg;
    assign code_wide     = 32'(code);
    assign code_in_range = code_wide < 32'(XLEN);
    assign mask_bit      = mask_sel[code[IDX_W-1:0]];
    assign low_priv      = (priv == PRV_USER) || (priv == PRV_SUPER);

    always_comb begin
        if (!trap_valid)
            target = TGT_NONE;
        else if (low_priv && code_in_range && mask_bit)
            target = TGT_SUPER;
        else
            target = TGT_MACH;
    end

    // R2: supervisor handling only from user or supervisor privilege
    assert_super_from_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (target == TGT_SUPER) |-> (priv == PRV_USER || priv == PRV_SUPER));

    // R8: converted environment-call code never stays generic outside user
    assert_ecall_converted_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && !is_irq && cause_raw == CAUSE_W'(ECALL_GENERIC) && priv != PRV_USER)
            |-> (code != CAUSE_W'(ECALL_GENERIC)));

endmodule

// File: rtl/trap_csr_update.sv
module trap_csr_update
    import trap_entry_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned CAUSE_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  target_e            target,
    input  logic               is_irq,
    input  logic [CAUSE_W-1:0] code,
    input  priv_e              priv,
    input  logic [XLEN-1:0]    status_in,
    input  logic [XLEN-1:0]    cur_pc,
    input  logic [XLEN-1:0]    fault_addr,
    output logic [XLEN-1:0]    status_out,
    output logic [XLEN-1:0]    cause_out,
    output logic [XLEN-1:0]    epc_out,
    output logic [XLEN-1:0]    tval_out
);
    logic addr_bearing;

    always_comb begin
        addr_bearing = 1'b0;
        if (!is_irq) begin
            case (code)
                CAUSE_W'(0), CAUSE_W'(1), CAUSE_W'(4), CAUSE_W'(5),
                CAUSE_W'(6), CAUSE_W'(7), CAUSE_W'(12), CAUSE_W'(13),
                CAUSE_W'(15): addr_bearing = 1'b1;
                default:      addr_bearing = 1'b0;
            endcase
        end
    end

    always_comb begin
        status_out = status_in;
        cause_out  = '0;
        epc_out    = '0;
        tval_out   = '0;
        unique case (target)
            TGT_SUPER: begin
                status_out[ST_SPIE] = status_in[ST_SIE];
                status_out[ST_SPP]  = priv[0];
                status_out[ST_SIE]  = 1'b0;
            end
            TGT_MACH: begin
                status_out[ST_MPIE]            = status_in[ST_MIE];
                status_out[ST_MPP_HI:ST_MPP_LO] = priv;
                status_out[ST_MIE]             = 1'b0;
            end
            default: ;
        endcase
        if (target != TGT_NONE) begin
            cause_out = {is_irq, (XLEN-1)'(code)};
            epc_out   = cur_pc;
            tval_out  = addr_bearing ? fault_addr : '0;
        end
    end

    // R3: supervisor entry leaves supervisor interrupts disabled
    assert_sie_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (target == TGT_SUPER) |-> !status_out[ST_SIE]);

    // R4: machine entry leaves machine interrupts disabled
    assert_mie_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (target == TGT_MACH) |-> !status_out[ST_MIE]);

    // R5: saved pc is the trapping pc
    assert_epc_saved_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (target != TGT_NONE) |-> (epc_out == cur_pc));

    // R6: interrupts never report a trap value
    assert_irq_no_tval_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (target != TGT_NONE && is_irq) |-> (tval_out == '0));

endmodule

// File: rtl/trap_vector_calc.sv
module trap_vector_calc
    import trap_entry_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned CAUSE_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  target_e            target,
    input  logic               is_irq,
    input  logic [CAUSE_W-1:0] code,
    input  logic [XLEN-1:0]    mvec,
    input  logic [XLEN-1:0]    svec,
    output logic [XLEN-1:0]    pc_out
);
    logic [XLEN-1:0] vec_sel;
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;

    assign vec_sel = (target == TGT_SUPER) ? svec : mvec;
    assign base    = {vec_sel[XLEN-1:2], 2'b00};
    assign offset  = (is_irq && vec_sel[1:0] == 2'd1) ? (XLEN'(code) << 2) : '0;

    always_comb begin
        unique case (target)
            TGT_SUPER, TGT_MACH: pc_out = base + offset;
            default:             pc_out = '0;
        endcase
    end

    // R7: exceptions always enter at the aligned base
    assert_sync_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (target != TGT_NONE && !is_irq) |-> (pc_out[1:0] == 2'b00));

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
    import trap_entry_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned CAUSE_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap_valid,
    input  logic               trap_is_irq,
    input  logic [CAUSE_W-1:0] trap_cause,
    input  logic [XLEN-1:0]    fault_addr,
    input  logic [XLEN-1:0]    cur_pc,
    input  logic [1:0]         cur_priv,
    input  logic [XLEN-1:0]    status_in,
    input  logic [XLEN-1:0]    exc_deleg,
    input  logic [XLEN-1:0]    irq_deleg,
    input  logic [XLEN-1:0]    mvec,
    input  logic [XLEN-1:0]    svec,
    input  logic               csr_we_in,
    output logic               csr_we_out,
    output logic               to_super,
    output logic               to_machine,
    output logic [XLEN-1:0]    status_out,
    output logic [XLEN-1:0]    cause_out,
    output logic [XLEN-1:0]    epc_out,
    output logic [XLEN-1:0]    tval_out,
    output logic [XLEN-1:0]    pc_out,
    output logic               resv_clear
);
    priv_e              priv;
    target_e            target;
    logic [CAUSE_W-1:0] code;

    assign priv = priv_e'(cur_priv);

    trap_route #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .trap_valid (trap_valid),
        .is_irq     (trap_is_irq),
        .cause_raw  (trap_cause),
        .priv       (priv),
        .exc_deleg  (exc_deleg),
        .irq_deleg  (irq_deleg),
        .code       (code),
        .target     (target)
    );

    trap_csr_update #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_update (
        .clk        (clk),
        .rst_n      (rst_n),
        .target     (target),
        .is_irq     (trap_is_irq),
        .code       (code),
        .priv       (priv),
        .status_in  (status_in),
        .cur_pc     (cur_pc),
        .fault_addr (fault_addr),
        .status_out (status_out),
        .cause_out  (cause_out),
        .epc_out    (epc_out),
        .tval_out   (tval_out)
    );

    trap_vector_calc #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_vector (
        .clk    (clk),
        .rst_n  (rst_n),
        .target (target),
        .is_irq (trap_is_irq),
        .code   (code),
        .mvec   (mvec),
        .svec   (svec),
        .pc_out (pc_out)
    );

    assign to_super   = (target == TGT_SUPER);
    assign to_machine = (target == TGT_MACH);
    assign resv_clear = (target != TGT_NONE);
    assign csr_we_out = csr_we_in && (target == TGT_NONE);

    // R2: exactly one handling level per trap
    assert_one_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> ($countones({to_super, to_machine}) == 1));

    // R9: a trap always drops the reservation
    assert_resv_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> resv_clear);

    // R10: no ordinary register write coincides with trap handling
    assert_we_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        csr_we_out |-> (!to_super && !to_machine));

    // R11: idle cycles pass the status word through
    assert_idle_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid |-> (status_out == status_in && pc_out == '0));

endmodule

// File: tb/trap_entry_unit_tb.sv
module trap_entry_unit_tb;
    localparam int unsigned XLEN       = 32;
    localparam int unsigned CAUSE_W    = 6;
    localparam time         CLK_PERIOD = 10ns;
    localparam int          WD_CYCLES  = 5000;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               trap_valid = 1'b0;
    logic               trap_is_irq = 1'b0;
    logic [CAUSE_W-1:0] trap_cause = '0;
    logic [XLEN-1:0]    fault_addr = '0;
    logic [XLEN-1:0]    cur_pc = '0;
    logic [1:0]         cur_priv = 2'd3;
    logic [XLEN-1:0]    status_in = '0;
    logic [XLEN-1:0]    exc_deleg = '0;
    logic [XLEN-1:0]    irq_deleg = '0;
    logic [XLEN-1:0]    mvec = '0;
    logic [XLEN-1:0]    svec = '0;
    logic               csr_we_in = 1'b0;
    logic               csr_we_out;
    logic               to_super;
    logic               to_machine;
    logic [XLEN-1:0]    status_out;
    logic [XLEN-1:0]    cause_out;
    logic [XLEN-1:0]    epc_out;
    logic [XLEN-1:0]    tval_out;
    logic [XLEN-1:0]    pc_out;
    logic               resv_clear;

    int checks = 0;
    int failures = 0;

    trap_entry_unit #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_is_irq(trap_is_irq),
        .trap_cause(trap_cause), .fault_addr(fault_addr), .cur_pc(cur_pc),
        .cur_priv(cur_priv), .status_in(status_in), .exc_deleg(exc_deleg),
        .irq_deleg(irq_deleg), .mvec(mvec), .svec(svec), .csr_we_in(csr_we_in),
        .csr_we_out(csr_we_out), .to_super(to_super), .to_machine(to_machine),
        .status_out(status_out), .cause_out(cause_out), .epc_out(epc_out),
        .tval_out(tval_out), .pc_out(pc_out), .resv_clear(resv_clear)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // apply one trap on the falling edge and let combinational outputs settle
    task automatic fire(input logic irq, input logic [CAUSE_W-1:0] cause,
                        input logic [1:0] priv);
        @(negedge clk);
        trap_valid  = 1'b1;
        trap_is_irq = irq;
        trap_cause  = cause;
        cur_priv    = priv;
        #1;
    endtask

    task automatic go_idle();
        @(negedge clk);
        trap_valid = 1'b0;
        #1;
    endtask

    task automatic t_reset_idle();
        #1;
        chk("R11", "reset to_super", 32'(to_super), 32'd0);
        chk("R11", "reset to_machine", 32'(to_machine), 32'd0);
        chk("R9", "reset resv_clear", 32'(resv_clear), 32'd0);
        chk("R11", "reset pc_out", pc_out, 32'd0);
    endtask

    task automatic t_exc_delegated_user();
        status_in = 32'hA000_0002; exc_deleg = 32'h0000_2000; irq_deleg = '0;
        svec = 32'h8000_0101; mvec = 32'h1000_0000;
        cur_pc = 32'h0000_4444; fault_addr = 32'h1234_5678; csr_we_in = 1'b1;
        fire(1'b0, 6'd13, 2'd0);
        chk("R2", "user load page fault to_super", 32'(to_super), 32'd1);
        chk("R1", "exception uses exc mask", 32'(to_machine), 32'd0);
        chk("R3", "super entry status", status_out, 32'hA000_0020);
        chk("R5", "exception cause word", cause_out, 32'd13);
        chk("R5", "epc", epc_out, 32'h0000_4444);
        chk("R6", "tval address cause", tval_out, 32'h1234_5678);
        chk("R7", "sync pc ignores vector mode", pc_out, 32'h8000_0100);
        chk("R9", "resv_clear on trap", 32'(resv_clear), 32'd1);
        chk("R10", "write blocked", 32'(csr_we_out), 32'd0);
        go_idle();
    endtask

    task automatic t_machine_priv_no_deleg();
        status_in = 32'h0000_0008; exc_deleg = 32'hFFFF_FFFF;
        mvec = 32'h1000_0003; cur_pc = 32'h0000_0100;
        fire(1'b0, 6'd13, 2'd3);
        chk("R2", "machine priv ignores deleg", 32'(to_machine), 32'd1);
        chk("R4", "machine entry from M", status_out, 32'h0000_1880);
        chk("R7", "machine base aligned", pc_out, 32'h1000_0000);
        status_in = 32'h0000_000A; exc_deleg = '0;
        fire(1'b0, 6'd2, 2'd1);
        chk("R2", "super priv without bit", 32'(to_machine), 32'd1);
        chk("R4", "machine entry from S", status_out, 32'h0000_0882);
        chk("R6", "illegal-instr no tval", tval_out, 32'd0);
        go_idle();
    endtask

    task automatic t_irq_mask_select();
        status_in = 32'h0000_0002; exc_deleg = 32'h0000_0020; irq_deleg = '0;
        svec = 32'h4000_0001; mvec = 32'h2000_0001; fault_addr = 32'hFFFF_0000;
        fire(1'b1, 6'd5, 2'd1);
        chk("R1", "irq ignores exc mask", 32'(to_machine), 32'd1);
        exc_deleg = '0; irq_deleg = 32'h0000_0020;
        fire(1'b1, 6'd5, 2'd1);
        chk("R1", "irq uses irq mask", 32'(to_super), 32'd1);
        chk("R3", "super entry from S", status_out, 32'h0000_0120);
        chk("R5", "irq cause word", cause_out, 32'h8000_0005);
        chk("R6", "irq no tval", tval_out, 32'd0);
        chk("R7", "super vectored pc", pc_out, 32'h4000_0014);
        svec = 32'h4000_0002;
        fire(1'b1, 6'd5, 2'd1);
        chk("R7", "mode 2 not vectored", pc_out, 32'h4000_0000);
        irq_deleg = '0;
        fire(1'b1, 6'd11, 2'd3);
        chk("R7", "machine vectored pc", pc_out, 32'h2000_002C);
        chk("R5", "machine irq cause", cause_out, 32'h8000_000B);
        go_idle();
    endtask

    task automatic t_cause_out_of_range();
        exc_deleg = 32'hFFFF_FFFF; mvec = 32'h3000_0000;
        fire(1'b0, 6'd40, 2'd0);
        chk("R2", "code >= XLEN not delegated", 32'(to_machine), 32'd1);
        chk("R5", "wide cause word", cause_out, 32'd40);
        chk("R7", "wide cause pc", pc_out, 32'h3000_0000);
        go_idle();
    endtask

    task automatic t_ecall_convert();
        exc_deleg = 32'h0000_0200; status_in = 32'h0000_0002; svec = 32'h5000_0000;
        fire(1'b0, 6'd8, 2'd0);
        chk("R8", "ecall from user code", cause_out, 32'd8);
        chk("R8", "user ecall uses bit 8 -> machine", 32'(to_machine), 32'd1);
        fire(1'b0, 6'd8, 2'd1);
        chk("R8", "ecall from super code", cause_out, 32'd9);
        chk("R8", "super ecall delegated by bit 9", 32'(to_super), 32'd1);
        chk("R6", "ecall no tval", tval_out, 32'd0);
        exc_deleg = 32'h0000_0100;
        fire(1'b0, 6'd8, 2'd1);
        chk("R8", "bit 8 alone not used for super ecall", 32'(to_machine), 32'd1);
        fire(1'b0, 6'd8, 2'd3);
        chk("R8", "ecall from machine code", cause_out, 32'd11);
        go_idle();
    endtask

    task automatic t_tval_table();
        exc_deleg = '0; fault_addr = 32'hDEAD_BEE0;
        for (int i = 0; i < 16; i++) begin
            logic [XLEN-1:0] exp;
            case (i)
                0, 1, 4, 5, 6, 7, 12, 13, 15: exp = 32'hDEAD_BEE0;
                default:                      exp = 32'd0;
            endcase
            fire(1'b0, 6'(i), 2'd3);
            chk("R6", $sformatf("tval cause %0d", i), tval_out, exp);
        end
        go_idle();
    endtask

    task automatic t_no_trap();
        @(negedge clk);
        trap_valid = 1'b0; status_in = 32'h5555_AAAA; csr_we_in = 1'b1;
        trap_cause = 6'd13; cur_priv = 2'd0; exc_deleg = 32'hFFFF_FFFF;
        #1;
        chk("R11", "idle status passthrough", status_out, 32'h5555_AAAA);
        chk("R11", "idle cause zero", cause_out, 32'd0);
        chk("R11", "idle epc zero", epc_out, 32'd0);
        chk("R2", "idle no target", 32'({to_super, to_machine}), 32'd0);
        chk("R9", "idle resv_clear", 32'(resv_clear), 32'd0);
        chk("R10", "idle write passes", 32'(csr_we_out), 32'd1);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired act=running exp=done");
        summary_and_end();
    end

    initial begin
        t_reset_idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_exc_delegated_user();
        t_machine_priv_no_deleg();
        t_irq_mask_select();
        t_cause_out_of_range();
        t_ecall_convert();
        t_tval_table();
        t_no_trap();
        repeat (2) @(posedge clk);
        summary_and_end();
    end

endmodule